// File: doc/BRIEF.md
# Serial Dual-Channel Wiper Register

This block is the digital control logic of a two-channel, 256-step digitally controlled resistor. A host shifts 10-bit frames in over a three-wire serial link: a serial clock, an active-low select and a data line. Each frame carries a two-bit channel address followed by an eight-bit wiper code. When the select line rises, the code is written into the wiper latch that the address picks. Both latches come up at midscale after reset. The latched codes drive the resistor ladder, which is outside this block.

The serial inputs are sampled by the chip's system clock. They pass through synchronizers, and their edges are detected in that clock domain. The outgoing serial bit is the bit entered ten serial clocks earlier, so several devices can share one select line and one host data line in a chain. It is modelled as an open-drain pull-low enable. An active-low shutdown input raises per-channel terminal-control flags and releases the serial output. The latched codes are kept while shutdown is active.

Top module: `dual_wiper_ctrl`

## Requirements
- R1: A frame is 10 bits, entered most significant bit first: address bit 1, address bit 0, then code bits 7 down to 0. The code written is the last eight bits entered.
- R2: While the select is low, each rising serial clock edge shifts one data bit in. While the select is high, serial clock edges leave the shift register unchanged.
- R3: The wiper codes change only on a rising edge of the select line, never while bits are being shifted.
- R4: On the select rising edge, address 00 writes `wiper1_code` and address 01 writes `wiper2_code`.
- R5: `sdo_pull_low` is 1 exactly when the bit shifted in ten serial clocks earlier (the shift register's top bit) is 0 and shutdown is inactive. This lets a second frame shifted behind a first push the first out unchanged.
- R6: After reset both wiper codes are 0x80, the shift register holds all ones, and `sdo_pull_low` is 0.
- R7: While `shdn_n` is low, both bits of `term_a_open` and `wiper_to_b` are 1 and the wiper codes keep their values. After release the flags return to 0 with the codes unchanged.
- R8: While `shdn_n` is low, `sdo_pull_low` is 0 whatever the shift register holds.
- R9: Channels may be written one at a time in any order. A write to one channel leaves the other unchanged.
- R10: A frame whose address bit 1 is 1 (address 10 or 11) changes neither wiper code.
- R11: When a select-low window holds more or fewer than ten clocks, the latch update uses the last ten bits in the shift register, including bits left from earlier windows.
- R12: A frame whose select rises in the same sample as shutdown asserts is still written, and shutdown takes effect in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial interface |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_clk | input | 1 | Serial clock; its rising edge shifts data while selected |
| ser_cs_n | input | 1 | Active-low select; its rising edge loads a latch |
| ser_din | input | 1 | Serial data in |
| shdn_n | input | 1 | Active-low shutdown |
| sdo_pull_low | output | 1 | Open-drain enable for the chained serial output |
| wiper1_code | output | 8 | Latched code of channel 1 |
| wiper2_code | output | 8 | Latched code of channel 2 |
| term_a_open | output | 2 | Per channel: open the A terminal |
| wiper_to_b | output | 2 | Per channel: tie the wiper to the B terminal |

## Verification
A latch load on the select rising edge and the entry into shutdown can fall in the same system-clock cycle. Both inputs pass through synchronizers of equal depth. The bench provokes the overlap by raising the select and lowering the shutdown input in the same instant, with a channel-1 frame pending. It judges the result at the ports: the new code must appear on `wiper1_code` while both flag pairs are 1 and `sdo_pull_low` is 0, even though the shift register's top bit is 0.

// File: rtl/wpr_pkg.sv
package wpr_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 2;
  localparam int FRAME_W = DATA_W + ADDR_W;
  localparam int NUM_CH  = 2;
  localparam logic [DATA_W-1:0] MIDSCALE = DATA_W'(1) << (DATA_W - 1);
endpackage

// File: rtl/wpr_rst_sync.sv
module wpr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic core_rst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign core_rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/wpr_sync.sv
module wpr_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb pipe_d = {pipe_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
    else        pipe_q <= pipe_d;
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/wpr_serial_front.sv
module wpr_serial_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk,
  input  logic ser_cs_n,
  input  logic ser_din,
  input  logic shdn_n,
  output logic shift_en,
  output logic load_en,
  output logic din_s,
  output logic shdn_act
);
  localparam int         NUM_IN  = 4;
  localparam logic [3:0] RST_VEC = 4'b1010; // shdn_n, din, cs_n, sclk

  logic [NUM_IN-1:0] raw_vec;
  logic [NUM_IN-1:0] sync_vec;
  logic              sclk_s, cs_n_s, shdn_n_s;
  logic              sclk_prev_q, sclk_prev_d;
  logic              cs_prev_q, cs_prev_d;

  assign raw_vec = {shdn_n, ser_din, ser_cs_n, ser_clk};

  for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_sync
    wpr_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (RST_VEC[gi])
    ) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_vec[gi]),
      .q     (sync_vec[gi])
    );
  end

  assign sclk_s   = sync_vec[0];
  assign cs_n_s   = sync_vec[1];
  assign din_s    = sync_vec[2];
  assign shdn_n_s = sync_vec[3];

  always_comb begin
    sclk_prev_d = sclk_s;
    cs_prev_d   = cs_n_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      cs_prev_q   <= 1'b1;
    end else begin
      sclk_prev_q <= sclk_prev_d;
      cs_prev_q   <= cs_prev_d;
    end
  end

  // A serial clock edge seen in the sample where select is already high is dropped
  assign shift_en = sclk_s & ~sclk_prev_q & ~cs_n_s;
  assign load_en  = cs_n_s & ~cs_prev_q;
  assign shdn_act = ~shdn_n_s;
endmodule

// File: rtl/wpr_shift_reg.sv
module wpr_shift_reg #(
  parameter int FRAME_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               din,
  output logic [FRAME_W-1:0] shreg,
  output logic               sout
);
  logic [FRAME_W-1:0] sr_q;
  logic [FRAME_W-1:0] sr_d;

  always_comb begin
    sr_d = sr_q;
    if (shift_en) sr_d = {sr_q[FRAME_W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '1;
    else        sr_q <= sr_d;
  end

  assign shreg = sr_q;
  assign sout  = sr_q[FRAME_W-1];
endmodule

// File: rtl/wpr_wiper_bank.sv
module wpr_wiper_bank #(
  parameter int               NUM_CH = 2,
  parameter int               DATA_W = 8,
  parameter int               ADDR_W = 2,
  parameter logic [DATA_W-1:0] PRESET = '0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             data,
  output logic [NUM_CH-1:0][DATA_W-1:0] codes
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic              hit;
    logic [DATA_W-1:0] code_q;
    logic [DATA_W-1:0] code_d;

    assign hit = load_en && (addr == ADDR_W'(ch));

    always_comb begin
      code_d = code_q;
      if (hit) code_d = data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code_q <= PRESET;
      else        code_q <= code_d;
    end

    assign codes[ch] = code_q;
  end
endmodule

// File: rtl/dual_wiper_ctrl.sv
module dual_wiper_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_clk,
  input  logic       ser_cs_n,
  input  logic       ser_din,
  input  logic       shdn_n,
  output logic       sdo_pull_low,
  output logic [7:0] wiper1_code,
  output logic [7:0] wiper2_code,
  output logic [1:0] term_a_open,
  output logic [1:0] wiper_to_b
);
  import wpr_pkg::*;

  logic                          core_rst_n;
  logic                          shift_en;
  logic                          load_en;
  logic                          din_s;
  logic                          shdn_act;
  logic [FRAME_W-1:0]            shreg;
  logic                          sout;
  logic [NUM_CH-1:0][DATA_W-1:0] codes;

  wpr_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_rst_n (core_rst_n)
  );

  wpr_serial_front #(.SYNC_STAGES(SYNC_STAGES)) i_front (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .ser_clk  (ser_clk),
    .ser_cs_n (ser_cs_n),
    .ser_din  (ser_din),
    .shdn_n   (shdn_n),
    .shift_en (shift_en),
    .load_en  (load_en),
    .din_s    (din_s),
    .shdn_act (shdn_act)
  );

  wpr_shift_reg #(.FRAME_W(FRAME_W)) i_shift (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .shift_en (shift_en),
    .din      (din_s),
    .shreg    (shreg),
    .sout     (sout)
  );

  wpr_wiper_bank #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .PRESET (MIDSCALE)
  ) i_bank (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .load_en (load_en),
    .addr    (shreg[FRAME_W-1:DATA_W]),
    .data    (shreg[DATA_W-1:0]),
    .codes   (codes)
  );

  assign wiper1_code  = codes[0];
  assign wiper2_code  = codes[1];
  assign sdo_pull_low = ~sout & ~shdn_act;
  assign term_a_open  = {NUM_CH{shdn_act}};
  assign wiper_to_b   = {NUM_CH{shdn_act}};
endmodule

// File: rtl/wpr_checker.sv
module wpr_checker #(
  parameter int FRAME_W = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               core_rst_n,
  input logic               shift_en,
  input logic               load_en,
  input logic               din_s,
  input logic               shdn_act,
  input logic [FRAME_W-1:0] shreg,
  input logic               sdo_pull_low,
  input logic [7:0]         wiper1_code,
  input logic [7:0]         wiper2_code
);
  p_shift_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> shreg == {$past(shreg[FRAME_W-2:0]), $past(din_s)});

  p_no_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(shreg));

  p_hold_codes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(wiper1_code) && $stable(wiper2_code));

  p_load_ch1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_en && shreg[FRAME_W-1:FRAME_W-2] == 2'b00 |=>
      wiper1_code == $past(shreg[7:0]) && $stable(wiper2_code));

  p_load_ch2_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_en && shreg[FRAME_W-1:FRAME_W-2] == 2'b01 |=>
      wiper2_code == $past(shreg[7:0]) && $stable(wiper1_code));

  p_preset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst_n) |-> wiper1_code == 8'h80 && wiper2_code == 8'h80 && !sdo_pull_low);

  p_sdo_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_act |-> !sdo_pull_low);

  p_ignore_high_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load_en && shreg[FRAME_W-1] |=> $stable(wiper1_code) && $stable(wiper2_code));
endmodule

bind dual_wiper_ctrl wpr_checker #(.FRAME_W(wpr_pkg::FRAME_W)) i_wpr_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .core_rst_n   (core_rst_n),
  .shift_en     (shift_en),
  .load_en      (load_en),
  .din_s        (din_s),
  .shdn_act     (shdn_act),
  .shreg        (shreg),
  .sdo_pull_low (sdo_pull_low),
  .wiper1_code  (wiper1_code),
  .wiper2_code  (wiper2_code)
);

// File: tb/test_dual_wiper_ctrl.sv
module test_dual_wiper_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ser_clk, ser_cs_n, ser_din, shdn_n;
  logic       sdo_pull_low;
  logic [7:0] wiper1_code, wiper2_code;
  logic [1:0] term_a_open, wiper_to_b;
  int         checks = 0;
  int         fails  = 0;

  always #10 clk = ~clk;

  dual_wiper_ctrl i_dual_wiper_ctrl (
    .clk (clk), .rst_n (rst_n), .ser_clk (ser_clk), .ser_cs_n (ser_cs_n),
    .ser_din (ser_din), .shdn_n (shdn_n), .sdo_pull_low (sdo_pull_low),
    .wiper1_code (wiper1_code), .wiper2_code (wiper2_code),
    .term_a_open (term_a_open), .wiper_to_b (wiper_to_b)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_open();
    ser_cs_n = 1'b0;
    wclk(4);
  endtask

  task automatic cs_close();
    ser_clk = 1'b0;
    wclk(4);
    ser_cs_n = 1'b1;
    wclk(8);
  endtask

  // Shift n bits of val, MSB first; optionally check the outgoing bit before each rise
  task automatic shift_bits(input logic [9:0] val, input int n,
                            input bit do_chk, input logic [9:0] prev);
    for (int k = 0; k < n; k++) begin
      ser_clk = 1'b0;
      ser_din = val[n-1-k];
      wclk(4);
      if (do_chk) chk("R5 chained output", {15'd0, sdo_pull_low}, {15'd0, ~prev[9-k]});
      ser_clk = 1'b1;
      wclk(4);
    end
  endtask

  task automatic frame(input logic [1:0] addr, input logic [7:0] data);
    cs_open();
    shift_bits({addr, data}, 10, 1'b0, 10'd0);
    cs_close();
  endtask

  task automatic t_reset();
    chk("R6 wiper1 preset", {8'd0, wiper1_code}, 16'h80);
    chk("R6 wiper2 preset", {8'd0, wiper2_code}, 16'h80);
    chk("R6 sdo released", {15'd0, sdo_pull_low}, 16'd0);
    chk("R7 flags idle", {12'd0, term_a_open, wiper_to_b}, 16'd0);
  endtask

  task automatic t_write_both();
    frame(2'b00, 8'h3C);
    chk("R1 R4 ch1 written", {8'd0, wiper1_code}, 16'h3C);
    chk("R9 ch2 untouched", {8'd0, wiper2_code}, 16'h80);
    frame(2'b01, 8'hA5);
    chk("R4 ch2 written", {8'd0, wiper2_code}, 16'hA5);
    chk("R9 ch1 kept", {8'd0, wiper1_code}, 16'h3C);
  endtask

  task automatic t_clock_deselected();
    // select high: ones on the data line must not enter; top bit stays 0
    ser_din = 1'b1;
    for (int k = 0; k < 10; k++) begin
      ser_clk = 1'b1; wclk(4);
      ser_clk = 1'b0; wclk(4);
    end
    chk("R2 no shift while deselected", {15'd0, sdo_pull_low}, 16'd1);
    frame(2'b00, 8'h77);
    chk("R3 ch1 after clean frame", {8'd0, wiper1_code}, 16'h77);
    chk("R2 ch2 unchanged", {8'd0, wiper2_code}, 16'hA5);
  endtask

  task automatic t_high_addr();
    frame(2'b10, 8'h11);
    chk("R10 addr 10 ch1", {8'd0, wiper1_code}, 16'h77);
    chk("R10 addr 10 ch2", {8'd0, wiper2_code}, 16'hA5);
    frame(2'b11, 8'h22);
    chk("R10 addr 11 ch1", {8'd0, wiper1_code}, 16'h77);
    chk("R10 addr 11 ch2", {8'd0, wiper2_code}, 16'hA5);
  endtask

  task automatic t_odd_counts();
    cs_open();
    shift_bits(10'b111, 3, 1'b0, 10'd0);
    shift_bits({2'b00, 8'h5A}, 10, 1'b0, 10'd0);
    cs_close();
    chk("R11 long window last ten bits", {8'd0, wiper1_code}, 16'h5A);
    // four bits 1011 behind 00_0101_1010 give 01_1010_1011
    cs_open();
    shift_bits(10'b1011, 4, 1'b0, 10'd0);
    cs_close();
    chk("R11 short window reuses old bits", {8'd0, wiper2_code}, 16'hAB);
    chk("R11 ch1 kept", {8'd0, wiper1_code}, 16'h5A);
  endtask

  task automatic t_chain();
    cs_open();
    shift_bits({2'b00, 8'hC3}, 10, 1'b0, 10'd0);
    shift_bits({2'b01, 8'h66}, 10, 1'b1, {2'b00, 8'hC3});
    cs_close();
    chk("R5 chain tail frame loaded", {8'd0, wiper2_code}, 16'h66);
    chk("R5 ch1 not loaded", {8'd0, wiper1_code}, 16'h5A);
  endtask

  task automatic t_shutdown();
    chk("R5 output low before shutdown", {15'd0, sdo_pull_low}, 16'd1);
    shdn_n = 1'b0;
    wclk(6);
    chk("R7 flags on", {12'd0, term_a_open, wiper_to_b}, 16'hF);
    chk("R8 output released", {15'd0, sdo_pull_low}, 16'd0);
    chk("R7 codes kept", {wiper1_code, wiper2_code}, 16'h5A66);
    shdn_n = 1'b1;
    wclk(6);
    chk("R7 flags off", {12'd0, term_a_open, wiper_to_b}, 16'd0);
    chk("R7 codes after release", {wiper1_code, wiper2_code}, 16'h5A66);
    chk("R8 output back", {15'd0, sdo_pull_low}, 16'd1);
  endtask

  task automatic t_load_and_shutdown();
    cs_open();
    shift_bits({2'b00, 8'h0F}, 10, 1'b0, 10'd0);
    ser_clk = 1'b0;
    wclk(4);
    ser_cs_n = 1'b1;
    shdn_n   = 1'b0;
    wclk(8);
    chk("R12 write taken with shutdown", {8'd0, wiper1_code}, 16'h0F);
    chk("R12 flags set", {12'd0, term_a_open, wiper_to_b}, 16'hF);
    chk("R12 output released", {15'd0, sdo_pull_low}, 16'd0);
    shdn_n = 1'b1;
    wclk(6);
    chk("R12 code kept after release", {8'd0, wiper1_code}, 16'h0F);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ser_clk = 1'b0; ser_cs_n = 1'b1; ser_din = 1'b0; shdn_n = 1'b1;
    wclk(5);
    rst_n = 1'b1;
    wclk(6);
    t_reset();
    t_write_both();
    t_clock_deselected();
    t_high_addr();
    t_odd_counts();
    t_chain();
    t_shutdown();
    t_load_and_shutdown();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule